// File: doc/BRIEF.md
# Stride-8 Input Reorder Scheduler

This block sits in front of a single shared eight-point FFT engine that is reused over time to build a 64-point transform. Complex samples arrive one per accepted cycle on a serial input. The block holds them in a chain of delay registers. Once a frame has been gathered far enough, it hands the engine eight samples at once. Group `i` carries the samples whose frame addresses are `8j + i`, for `j = 0..7`.

The eight groups leave in order. Group 0 leaves on the cycle that accepts frame address 56, and group 1 leaves on the cycle that accepts address 57. A new group follows each time a sample is accepted, up to group 7 at address 63. This works because every sample a group needs has already arrived by then. A 6-bit frame counter wraps after address 63, so frames run back to back without any gap.

The block also issues write-back tags for the multiplier that follows the engine. Each tag names the group and its eight strided addresses. A tag appears a fixed number of cycles (`WB_LAT`) after its group was issued, which lets engines with different pipeline depths be matched. With the default latency of 8 and a gap-free input, the last tag of a frame comes out 71 cycles after that frame's first sample.

Top module: `stride8_reorder_sched`

## Requirements
- R1: While `rst_n` is low, `grp_start` and `wb_valid` read 0. The first sample accepted after reset is frame address 0.
- R2: `grp_start` is high for exactly one cycle after each edge that accepts frame address `56 + i`, for `i = 0..7`, and `grp_idx` then reads `i`. No group is issued for addresses 0 to 55.
- R3: While `grp_start` is high, lane `j` of `grp_re` and `grp_im` (bits `[j*SAMPLE_W +: SAMPLE_W]`) holds the sample at address `8j + grp_idx` of the current frame.
- R4: A cycle with `in_valid` low accepts no sample. It moves neither the counter nor the delay registers, and no group is issued after it.
- R5: After address 63 the counter wraps to 0. The next frame follows the same schedule, and no group is issued in the cycle after group 7.
- R6: `wb_valid` pulses exactly `WB_LAT` cycles after each `grp_start` pulse, and `wb_grp` equals the `grp_idx` of that group.
- R7: While `wb_valid` is high, lane `j` of `wb_addr` (bits `[j*6 +: 6]`) equals `8j + wb_grp`.
- R8: With `in_valid` held high, the groups of a frame are issued on eight consecutive cycles with `grp_idx` counting 0 to 7. With the default `WB_LAT` of 8, the last tag appears 71 edges after the frame's first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The serial sample is accepted this cycle |
| in_re | input | SAMPLE_W | Real part of the serial sample |
| in_im | input | SAMPLE_W | Imaginary part of the serial sample |
| grp_start | output | 1 | One-cycle pulse: a group is presented to the engine |
| grp_idx | output | 3 | Index `i` of the presented group |
| grp_re | output | 8*SAMPLE_W | Real parts, lane `j` = address `8j+i` |
| grp_im | output | 8*SAMPLE_W | Imaginary parts, lane `j` = address `8j+i` |
| wb_valid | output | 1 | Write-back tag valid |
| wb_grp | output | 3 | Group index of the write-back tag |
| wb_addr | output | 8*6 | Eight write-back addresses, lane `j` = `8j + wb_grp` |

## Verification
If the frame counter is off by even one position, the first `grp_start` shows it: the pulse comes a cycle early or late, or carries the wrong `grp_idx`, on the first frame and within 57 cycles of reset. A wrong tap or a delay register that moves during a stall puts a neighbouring address into some lane of `grp_re`/`grp_im`, which is visible on the very pulse that uses it. Stalls are therefore spread across the issue window. A lag pipeline of the wrong depth shifts `wb_valid` against the reference queue as soon as the first tag is due. The bench checks every output on every cycle, so each of these faults appears within the frame that carries it.

// File: rtl/s8rs_pkg.sv
package s8rs_pkg;

   // Number of samples that precede the first issue: (radix-1) * radix
   function automatic int unsigned fill_count(input int unsigned radix);
      return (radix - 1) * radix;
   endfunction

   // Delay-register position holding lane j when group i is issued.
   // It does not depend on i, because the issuing sample itself is lane radix-1.
   function automatic int unsigned tap_pos(input int unsigned radix, input int unsigned lane);
      return fill_count(radix) - 1 - radix * lane;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/s8rs_issue_ctl.sv
module s8rs_issue_ctl #(
   parameter int unsigned RADIX = 8,
   parameter int unsigned AW    = 6,
   parameter int unsigned GW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic          issue,
   output logic [GW-1:0] issue_idx
);
   import s8rs_pkg::*;

   localparam int unsigned FILL = fill_count(RADIX);

   logic [AW-1:0] addr_q;
   logic [AW-1:0] rel;

   // Frame address of the sample accepted this cycle; wraps at RADIX*RADIX
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   addr_q <= '0;
      else if (adv) addr_q <= addr_q + 1'b1;
   end

   assign rel       = addr_q - AW'(FILL);
   assign issue     = adv && (addr_q >= AW'(FILL));
   assign issue_idx = rel[GW-1:0];

endmodule

// File: rtl/s8rs_tap_line.sv
module s8rs_tap_line #(
   parameter int unsigned DW    = 32,
   parameter int unsigned RADIX = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_en,
   input  logic [DW-1:0]       din,
   output logic [RADIX*DW-1:0] taps
);
   import s8rs_pkg::*;

   localparam int unsigned DEPTH = fill_count(RADIX);

   logic [DW-1:0] stage [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
      end else if (shift_en) begin
         stage[0] <= din;
         for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
      end
   end

   // Lanes 0..RADIX-2 come from fixed taps; the last lane is the arriving sample
   for (genvar j = 0; j < RADIX - 1; j++) begin : g_tap
      assign taps[j*DW +: DW] = stage[tap_pos(RADIX, j)];
   end
   assign taps[(RADIX-1)*DW +: DW] = din;

endmodule

// File: rtl/s8rs_wb_lag.sv
module s8rs_wb_lag #(
   parameter int unsigned LAT = 8,
   parameter int unsigned GW  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [GW-1:0] in_idx,
   output logic          out_vld,
   output logic [GW-1:0] out_idx
);
   if (LAT == 0) begin : g_bypass
      assign out_vld = in_vld;
      assign out_idx = in_idx;
   end else begin : g_pipe
      logic          vld_q [LAT];
      logic [GW-1:0] idx_q [LAT];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < LAT; k++) begin
               vld_q[k] <= 1'b0;
               idx_q[k] <= '0;
            end
         end else begin
            vld_q[0] <= in_vld;
            idx_q[0] <= in_idx;
            for (int k = 1; k < LAT; k++) begin
               vld_q[k] <= vld_q[k-1];
               idx_q[k] <= idx_q[k-1];
            end
         end
      end

      assign out_vld = vld_q[LAT-1];
      assign out_idx = idx_q[LAT-1];
   end

endmodule

// File: rtl/stride8_reorder_sched.sv
module stride8_reorder_sched #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned RADIX    = 8,
   parameter int unsigned WB_LAT   = 8,
   localparam int unsigned NPTS    = RADIX * RADIX,
   localparam int unsigned AW      = $clog2(NPTS),
   localparam int unsigned GW      = $clog2(RADIX)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [SAMPLE_W-1:0]       in_re,
   input  logic [SAMPLE_W-1:0]       in_im,
   output logic                      grp_start,
   output logic [GW-1:0]             grp_idx,
   output logic [RADIX*SAMPLE_W-1:0] grp_re,
   output logic [RADIX*SAMPLE_W-1:0] grp_im,
   output logic                      wb_valid,
   output logic [GW-1:0]             wb_grp,
   output logic [RADIX*AW-1:0]       wb_addr
);
   import s8rs_pkg::*;

   localparam int unsigned CW = 2 * SAMPLE_W;

   // Elaboration-time parameter checks
   if (!is_pow2(RADIX) || RADIX < 2) begin : g_bad_radix
      $error("RADIX must be a power of two of at least 2");
   end
   if (SAMPLE_W < 1) begin : g_bad_width
      $error("SAMPLE_W must be at least 1");
   end

   logic                   issue;
   logic [GW-1:0]          issue_idx;
   logic [RADIX*CW-1:0]    taps;
   logic [RADIX*SAMPLE_W-1:0] tap_re;
   logic [RADIX*SAMPLE_W-1:0] tap_im;

   s8rs_issue_ctl #(.RADIX(RADIX), .AW(AW), .GW(GW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (in_valid),
      .issue     (issue),
      .issue_idx (issue_idx)
   );

   s8rs_tap_line #(.DW(CW), .RADIX(RADIX)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .din      ({in_re, in_im}),
      .taps     (taps)
   );

   for (genvar j = 0; j < RADIX; j++) begin : g_split
      assign tap_re[j*SAMPLE_W +: SAMPLE_W] = taps[j*CW + SAMPLE_W +: SAMPLE_W];
      assign tap_im[j*SAMPLE_W +: SAMPLE_W] = taps[j*CW +: SAMPLE_W];
   end

   // Group register presented to the eight-point engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_start <= 1'b0;
         grp_idx   <= '0;
         grp_re    <= '0;
         grp_im    <= '0;
      end else begin
         grp_start <= issue;
         if (issue) begin
            grp_idx <= issue_idx;
            grp_re  <= tap_re;
            grp_im  <= tap_im;
         end
      end
   end

   s8rs_wb_lag #(.LAT(WB_LAT), .GW(GW)) u_lag (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (grp_start),
      .in_idx  (grp_idx),
      .out_vld (wb_valid),
      .out_idx (wb_grp)
   );

   // Strided write-back addresses: lane j -> j*RADIX + group
   for (genvar j = 0; j < RADIX; j++) begin : g_wb_addr
      assign wb_addr[j*AW +: AW] = {GW'(j), wb_grp};
   end

endmodule

// File: rtl/s8rs_chk.sv
module s8rs_chk #(
   parameter int unsigned RADIX  = 8,
   parameter int unsigned WB_LAT = 8,
   parameter int unsigned GW     = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          grp_start,
   input logic [GW-1:0] grp_idx,
   input logic          wb_valid,
   input logic [GW-1:0] wb_grp
);
   // Tags issued but not yet written back
   logic [15:0] pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend + 16'(grp_start) - 16'(wb_valid);
   end

   // R1: outputs are quiet during reset
   p_quiet_in_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!grp_start && !wb_valid));

   // R4: a stalled cycle never issues a group
   p_no_issue_on_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !grp_start);

   // R5: the frame wraps after the last group, no group follows directly
   p_gap_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_start && grp_idx == GW'(RADIX - 1)) |=> !grp_start);

   // R8: back-to-back issues count up by one
   p_issue_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_start && $past(grp_start)) |-> (grp_idx == $past(grp_idx) + 1'b1));

   // R6: a tag never appears without an issued group
   p_tag_has_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ((pend + 16'(grp_start)) != 16'd0));

   // R6: no more than WB_LAT groups wait for their tag
   p_bounded_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= 16'(WB_LAT));

   // R6: back-to-back tags keep the group order
   p_tag_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && $past(wb_valid)) |-> (wb_grp == $past(wb_grp) + 1'b1));

endmodule

bind stride8_reorder_sched s8rs_chk #(.RADIX(RADIX), .WB_LAT(WB_LAT), .GW(GW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .grp_start (grp_start),
   .grp_idx   (grp_idx),
   .wb_valid  (wb_valid),
   .wb_grp    (wb_grp)
);

// File: tb/stride8_reorder_sched_tb.sv
`timescale 1ns/1ps
module stride8_reorder_sched_tb;
   localparam int W   = 16;
   localparam int R   = 8;
   localparam int LAT = 8;
   localparam int AW  = 6;
   localparam int GW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [W-1:0] in_re = '0, in_im = '0;
   logic grp_start, wb_valid;
   logic [GW-1:0] grp_idx, wb_grp;
   logic [R*W-1:0] grp_re, grp_im;
   logic [R*AW-1:0] wb_addr;

   always #2 clk = ~clk;   // 250 MHz

   stride8_reorder_sched #(.SAMPLE_W(W), .RADIX(R), .WB_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .grp_start(grp_start), .grp_idx(grp_idx), .grp_re(grp_re), .grp_im(grp_im),
      .wb_valid(wb_valid), .wb_grp(wb_grp), .wb_addr(wb_addr));

   int tests = 0, fails = 0;
   int cyc_no = 0;
   logic [W-1:0] mem_re [64];
   logic [W-1:0] mem_im [64];
   int addr = 0;
   int hv[$];
   int hi[$];
   int last_wb_cycle = -1;
   int frame_first_cycle = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc_no, act, exp);
      end
   endtask

   // Drive one cycle, advance the model, then compare after the edge
   task automatic step(input bit v, input logic [W-1:0] re, input logic [W-1:0] im);
      bit es; int ei;
      bit ew; int ewi;
      in_valid = v; in_re = re; in_im = im;
      es = 0; ei = 0;
      if (v) begin
         mem_re[addr] = re; mem_im[addr] = im;
         if (addr >= 56) begin es = 1; ei = addr - 56; end
         addr = (addr + 1) % 64;
      end
      hv.push_back(int'(es)); hi.push_back(ei);
      ew = bit'(hv.pop_front()); ewi = hi.pop_front();
      @(negedge clk);
      // R2 / R4: issue pulse timing
      check(grp_start == es, v ? "R2 issue pulse" : "R4 stall issue", grp_start, es);
      if (es && grp_start) begin
         logic [R*W-1:0] xr, xi;
         for (int j = 0; j < R; j++) begin
            xr[j*W +: W] = mem_re[8*j + ei];
            xi[j*W +: W] = mem_im[8*j + ei];
         end
         check(grp_idx == GW'(ei), "R2 group index", grp_idx, ei);
         check(grp_re == xr, "R3 real lanes", grp_re[63:0], xr[63:0]);
         check(grp_im == xi, "R3 imag lanes", grp_im[63:0], xi[63:0]);
      end
      check(wb_valid == ew, "R6 tag timing", wb_valid, ew);
      if (ew && wb_valid) begin
         logic [R*AW-1:0] xa;
         for (int j = 0; j < R; j++) xa[j*AW +: AW] = AW'(8*j + ewi);
         check(wb_grp == GW'(ewi), "R6 tag group", wb_grp, ewi);
         check(wb_addr == xa, "R7 write-back addresses", wb_addr, xa);
         last_wb_cycle = cyc_no;
      end
      cyc_no++;
   endtask

   function automatic logic [W-1:0] sre(input int f, input int a);
      return W'(f * 256 + a * 3 + 7);
   endfunction
   function automatic logic [W-1:0] sim_(input int f, input int a);
      return ~W'(f * 131 + a * 5);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(grp_start == 1'b0, "R1 reset grp_start", grp_start, 0);
      check(wb_valid == 1'b0, "R1 reset wb_valid", wb_valid, 0);
      rst_n = 1'b1;
      for (int k = 0; k < LAT; k++) begin hv.push_back(0); hi.push_back(0); end

      // Frame 0: gap-free, R8 milestones
      frame_first_cycle = cyc_no;
      for (int a = 0; a < 64; a++) step(1'b1, sre(0, a), sim_(0, a));
      for (int k = 0; k < LAT; k++) step(1'b0, '0, '0);
      // R8: last tag 71 edges after the first sample
      check(last_wb_cycle - frame_first_cycle == 71, "R8 last tag cycle",
            last_wb_cycle - frame_first_cycle, 71);

      // Frame 1: stalls every third cycle, including the issue window (R4)
      begin
         int a = 0; int k = 0;
         while (a < 64) begin
            if (k % 3 == 2) step(1'b0, W'(16'hdead), W'(16'hbeef));
            else begin step(1'b1, sre(1, a), sim_(1, a)); a++; end
            k++;
         end
      end

      // Frame 2 follows straight away: counter wrap (R5)
      for (int a = 0; a < 64; a++) step(1'b1, sre(2, a), sim_(2, a));
      // Frame 3 partial, then a long stall
      for (int a = 0; a < 60; a++) step(1'b1, sre(3, a), sim_(3, a));
      for (int k = 0; k < 12; k++) step(1'b0, '0, '0);
      // R5: frame 3 resumes exactly where it paused
      for (int a = 60; a < 64; a++) step(1'b1, sre(3, a), sim_(3, a));
      for (int k = 0; k < LAT + 2; k++) step(1'b0, '0, '0);

      // R1: reset again mid-stream clears outputs, first sample is address 0
      for (int a = 0; a < 58; a++) step(1'b1, sre(4, a), sim_(4, a));
      rst_n = 1'b0;
      @(negedge clk);
      check(grp_start == 1'b0 && wb_valid == 1'b0, "R1 reset mid-frame", {grp_start, wb_valid}, 0);
      rst_n = 1'b1;
      addr = 0; hv.delete(); hi.delete();
      for (int k = 0; k < LAT; k++) begin hv.push_back(0); hi.push_back(0); end
      for (int a = 0; a < 64; a++) step(1'b1, sre(5, a), sim_(5, a));
      for (int k = 0; k < LAT + 2; k++) step(1'b0, '0, '0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule